// File: doc/BRIEF.md
# Switchable-Ratio Clock Output Divider

This block takes a free-running crystal clock and produces a divided clock that an external microcontroller can use as its own clock. Four integer ratios are available (2, 3, 4 and 5). For a 10.24 MHz crystal that gives 5.12 MHz, about 3.413 MHz, 2.56 MHz and 2.048 MHz. Each ratio, odd or even, gives a square wave with equal high and low time. For odd ratios, the output flop updated on the falling crystal edge supplies the extra half crystal period.

The ratio can be changed while the output is running. A new ratio takes effect only at the end of a whole output period, at the moment the output is low. A mute control also takes effect only at a period end, and it then holds the output at a steady low. When mute is released, the output starts a fresh period that opens with a full high phase. No switch of ratio and no entry into or exit from mute can produce a shortened pulse.

The select and mute inputs are assumed to be synchronous to the crystal clock.

Top module: `mutable_clk_divider`

## Requirements
- R1: While reset is high, and from the crystal edge after reset is raised, the output is low.
- R2: Ratio code 0 (binary 00) divides by 2, code 1 (01) by 3, code 2 (10) by 4, code 3 (11) by 5. In steady state the high phase and the low phase each last N half periods of the crystal clock, where N is the ratio.
- R3: The first output period after reset divides by 5, whatever the ratio code. The ratio code is first sampled at the end of that period.
- R4: The ratio code is sampled only at the crystal rising edge that ends an output period. A change in the middle of a period leaves that period unchanged. Every high and low phase then lasts either the old or the new N half periods, and each high phase is followed by a low phase of the same length.
- R5: A mute request that arrives during a period lets that period finish with its normal high and low phases before the output stops.
- R6: While muted, the output stays low and changes on the ratio code have no effect on it.
- R7: When mute is released, the output goes high on the first crystal rising edge that samples mute low. It then runs a full period at the ratio code sampled on that edge, with N half periods high and N half periods low.
- R8: Output rising edges always follow crystal rising edges. Output falling edges follow crystal rising edges for even ratios and crystal falling edges for odd ratios.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xtal_clk | input | 1 | Crystal clock; both of its edges are used |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 2 | Division ratio code (N = 2 + code) |
| mute | input | 1 | Request to stop the output at a static low |
| mcu_clk | output | 1 | Divided clock for the microcontroller |

## Verification
The bench builds the block with its default parameters: a 2-bit ratio code, ratios 2 to 5, and divide-by-5 after reset. With these values every ratio, and every ordered pair of old and new ratios, can be exercised in a few hundred crystal cycles. The bench samples the output twice per crystal period, a quarter period after each edge. From these samples it rebuilds every high and low phase with its length and its starting edge. This lets it sweep all 16 ratio transitions at five different offsets within a period, enter and leave mute at every ratio, and apply a reset in the middle of a period.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    localparam int SEL_W      = 2;
    localparam int MIN_DIV    = 2;
    localparam int NUM_RATIOS = 1 << SEL_W;
    localparam int MAX_DIV    = MIN_DIV + NUM_RATIOS - 1;
    localparam int CNT_W      = $clog2(MAX_DIV + 1);

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [SEL_W-1:0] {
        DIV2 = 2'd0,
        DIV3 = 2'd1,
        DIV4 = 2'd2,
        DIV5 = 2'd3
    } ratio_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_MUTE = 2'd2
    } phase_e;

    // what the next rising edge does to the period counter
    typedef struct packed {
        logic   start;  // open a new period with a high phase
        logic   hold;   // park the counter with the output low
        ratio_e sel;    // ratio in force after this edge
    } step_t;

    function automatic cnt_t ratio_len(ratio_e r);
        return cnt_t'(MIN_DIV) + cnt_t'(r);
    endfunction

    function automatic cnt_t last_count(ratio_e r);
        return ratio_len(r) - cnt_t'(1);
    endfunction

    // whole crystal cycles the rising-edge flop stays high
    function automatic cnt_t high_count(ratio_e r);
        return ratio_len(r) >> 1;
    endfunction

    function automatic logic is_odd(ratio_e r);
        cnt_t n;
        n = ratio_len(r);
        return n[0];
    endfunction

endpackage

// File: rtl/clkdiv_ctrl.sv
`timescale 1ns/1ps
module clkdiv_ctrl
    import clkdiv_pkg::*;
#(
    parameter ratio_e RESET_SEL = DIV5
) (
    input  logic   clk,
    input  logic   rst,
    input  sel_t   sel_i,
    input  logic   mute_i,
    input  logic   at_end_i,
    output logic   start_o,
    output logic   hold_o,
    output ratio_e act_sel_o,
    output logic   muted_o
);

    phase_e state_q, state_d;
    ratio_e act_sel_q;
    step_t  step;

    always_comb begin
        state_d = state_q;
        step    = '{start: 1'b0, hold: 1'b0, sel: act_sel_q};
        unique case (state_q)
            ST_IDLE: begin
                if (mute_i) begin
                    state_d   = ST_MUTE;
                    step.hold = 1'b1;
                end else begin
                    state_d    = ST_RUN;
                    step.start = 1'b1;
                    step.sel   = RESET_SEL;
                end
            end
            ST_RUN: begin
                if (at_end_i) begin
                    if (mute_i) begin
                        state_d   = ST_MUTE;
                        step.hold = 1'b1;
                    end else begin
                        step.start = 1'b1;
                        step.sel   = ratio_e'(sel_i);
                    end
                end
            end
            ST_MUTE: begin
                if (!mute_i) begin
                    state_d    = ST_RUN;
                    step.start = 1'b1;
                    step.sel   = ratio_e'(sel_i);
                end else begin
                    step.hold = 1'b1;
                end
            end
            default: begin
                state_d   = ST_IDLE;
                step.hold = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            act_sel_q <= RESET_SEL;
        end else begin
            state_q   <= state_d;
            act_sel_q <= step.sel;
        end
    end

    assign start_o   = step.start;
    assign hold_o    = step.hold;
    assign act_sel_o = act_sel_q;
    assign muted_o   = (state_q == ST_MUTE);

    assert_sel_held_midperiod_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !at_end_i) |=> $stable(act_sel_q));

    assert_mute_waits_boundary_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !at_end_i) |=> (state_q == ST_RUN));

    assert_first_period_default_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !mute_i) |=> (act_sel_q == RESET_SEL));

endmodule

// File: rtl/clkdiv_count.sv
`timescale 1ns/1ps
module clkdiv_count
    import clkdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  logic   hold_i,
    input  ratio_e act_sel_i,
    output logic   at_end_o,
    output logic   pos_o
);

    cnt_t cnt_q, cnt_d;
    logic pos_q, pos_d;

    always_comb begin
        if (start_i) begin
            cnt_d = '0;
            pos_d = 1'b1;
        end else if (hold_i) begin
            cnt_d = '0;
            pos_d = 1'b0;
        end else begin
            cnt_d = cnt_q + cnt_t'(1);
            pos_d = (cnt_q + cnt_t'(1)) < high_count(act_sel_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pos_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            pos_q <= pos_d;
        end
    end

    assign at_end_o = (cnt_q == last_count(act_sel_i));
    assign pos_o    = pos_q;

    assert_count_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_count(act_sel_i));

    assert_high_phase_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(pos_q) |-> (cnt_q == high_count(act_sel_i)));

endmodule

// File: rtl/clkdiv_halfstep.sv
`timescale 1ns/1ps
module clkdiv_halfstep (
    input  logic clk,
    input  logic rst,
    input  logic pos_i,
    input  logic odd_i,
    output logic clk_o
);

    logic neg_q;

    // stretches the high phase by half a crystal period for odd ratios
    always_ff @(negedge clk) begin
        if (rst) neg_q <= 1'b0;
        else     neg_q <= pos_i & odd_i;
    end

    assign clk_o = pos_i | neg_q;

    assert_even_no_halfstep_R8: assert property (@(posedge clk) disable iff (rst)
        !odd_i |-> !neg_q);

endmodule

// File: rtl/mutable_clk_divider.sv
`timescale 1ns/1ps
module mutable_clk_divider
    import clkdiv_pkg::*;
#(
    parameter ratio_e RESET_SEL = DIV5
) (
    input  logic             xtal_clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             mute,
    output logic             mcu_clk
);

    logic   start, hold, at_end, pos_q, muted;
    ratio_e act_sel;

    clkdiv_ctrl #(.RESET_SEL(RESET_SEL)) u_ctrl (
        .clk       (xtal_clk),
        .rst       (rst),
        .sel_i     (ratio_sel),
        .mute_i    (mute),
        .at_end_i  (at_end),
        .start_o   (start),
        .hold_o    (hold),
        .act_sel_o (act_sel),
        .muted_o   (muted)
    );

    clkdiv_count u_count (
        .clk       (xtal_clk),
        .rst       (rst),
        .start_i   (start),
        .hold_i    (hold),
        .act_sel_i (act_sel),
        .at_end_o  (at_end),
        .pos_o     (pos_q)
    );

    clkdiv_halfstep u_half (
        .clk   (xtal_clk),
        .rst   (rst),
        .pos_i (pos_q),
        .odd_i (is_odd(act_sel)),
        .clk_o (mcu_clk)
    );

    assert_reset_low_R1: assert property (@(posedge xtal_clk)
        rst |=> !mcu_clk);

    assert_mute_static_low_R6: assert property (@(posedge xtal_clk) disable iff (rst)
        muted |-> !mcu_clk);

    assert_unmute_full_high_R7: assert property (@(posedge xtal_clk) disable iff (rst)
        $fell(muted) |-> mcu_clk);

endmodule

// File: tb/tb_mutable_clk_divider.sv
`timescale 1ns/1ps
module tb_mutable_clk_divider;

    logic       xtal_clk  = 1'b0;
    logic       rst       = 1'b1;
    logic       mute      = 1'b0;
    logic [1:0] ratio_sel = 2'b00;
    logic       mcu_clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 xtal_clk = ~xtal_clk;

    mutable_clk_divider dut (
        .xtal_clk  (xtal_clk),
        .rst       (rst),
        .ratio_sel (ratio_sel),
        .mute      (mute),
        .mcu_clk   (mcu_clk)
    );

    // run recorder: phase 0 = sample after rising edge, 1 = after falling edge
    localparam int MAXR = 4096;
    logic rlvl [MAXR];
    int   rlen [MAXR];
    logic rph  [MAXR];
    int   idx     = 0;
    bit   rec_en  = 0;
    logic cur_lvl = 1'b0;
    int   cur_len = 0;
    logic cur_ph  = 1'b0;

    task automatic take(input logic ph);
        logic s;
        s = mcu_clk;
        if (!rec_en) return;
        if (cur_len == 0) begin
            cur_lvl = s; cur_len = 1; cur_ph = ph;
        end else if (s === cur_lvl) begin
            cur_len++;
        end else begin
            if (idx < MAXR) begin
                rlvl[idx] = cur_lvl; rlen[idx] = cur_len; rph[idx] = cur_ph;
            end
            idx++;
            cur_lvl = s; cur_len = 1; cur_ph = ph;
        end
    endtask

    always @(posedge xtal_clk) begin #1.25; take(1'b0); end
    always @(negedge xtal_clk) begin #1.25; take(1'b1); end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic at_drive();
        @(posedge xtal_clk); #1;
    endtask

    task automatic wait_runs(input int target);
        while (idx < target) @(posedge xtal_clk);
    endtask

    initial begin
        #900000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n, na, nb, b, base, ph_exp, hb;
        bit ok;

        // R1: output low under reset
        for (int k = 0; k < 4; k++) begin
            @(negedge xtal_clk); #1.25;
            check(mcu_clk === 1'b0, "R1", "output during reset", int'(mcu_clk), 0);
        end
        at_drive(); rst = 1'b0; rec_en = 1;

        // R3: first period is divide-by-5 although code 00 is applied
        wait_runs(5);
        check(rlvl[1] == 1'b1 && rlen[1] == 5, "R3", "first high phase", rlen[1], 5);
        check(rlen[2] == 5, "R3", "first low phase", rlen[2], 5);
        check(rph[2] == 1'b1, "R8", "odd ratio falls after falling edge", int'(rph[2]), 1);
        check(rlvl[3] == 1'b1 && rlen[3] == 2, "R3", "code sampled after first period", rlen[3], 2);

        // R2, R8: steady sweep over all codes
        for (int s = 0; s < 4; s++) begin
            n = s + 2;
            at_drive(); ratio_sel = 2'(s);
            b = idx; wait_runs(b + 8);
            for (int i = b + 3; i < b + 7; i++) begin
                check(rlen[i] == n, "R2", $sformatf("code %0d phase length", s), rlen[i], n);
                ph_exp = rlvl[i] ? 0 : (n % 2);
                check(int'(rph[i]) == ph_exp, "R8", $sformatf("code %0d edge alignment", s),
                      int'(rph[i]), ph_exp);
            end
        end

        // R4: every ordered pair of ratios, changed at five offsets
        for (int a = 0; a < 4; a++) begin
            for (int c = 0; c < 4; c++) begin
                for (int off = 0; off < 5; off++) begin
                    na = a + 2; nb = c + 2;
                    at_drive(); ratio_sel = 2'(a);
                    b = idx; wait_runs(b + 4);
                    repeat (off) @(posedge xtal_clk);
                    at_drive(); ratio_sel = 2'(c);
                    base = idx; wait_runs(base + 7);
                    ok = (rlen[base] == na);
                    for (int i = base; i < base + 6; i++) begin
                        if (rlen[i] != na && rlen[i] != nb) ok = 0;
                        if (rlvl[i] && rlen[i + 1] != rlen[i]) ok = 0;
                    end
                    check(ok, "R4", $sformatf("switch %0d->%0d off %0d no runt", a, c, off),
                          rlen[base], na);
                    check(rlen[base + 4] == nb && rlen[base + 5] == nb, "R4",
                          $sformatf("switch %0d->%0d off %0d settles", a, c, off),
                          rlen[base + 5], nb);
                end
            end
        end

        // R5, R6, R7: mute entry during a high phase and release at each code
        for (int c = 0; c < 4; c++) begin
            na = ((c + 1) % 4) + 2; nb = c + 2;
            at_drive(); ratio_sel = 2'((c + 1) % 4);
            b = idx; wait_runs(b + 5);
            do begin
                @(posedge xtal_clk); #1;
            end while (mcu_clk !== 1'b1);
            mute = 1'b1;
            #0.5; base = idx;
            for (int k = 0; k < 30; k++) begin
                at_drive(); ratio_sel = 2'(k);
            end
            check(idx == base + 1 && rlvl[base] == 1'b1 && rlen[base] == na, "R5",
                  "period finishes before mute", rlen[base], na);
            check(cur_lvl == 1'b0 && cur_len >= 50, "R6", "static low while muted",
                  cur_len, 50);
            at_drive(); ratio_sel = 2'(c); mute = 1'b0;
            #2.75;
            check(mcu_clk === 1'b0, "R7", "still low before sampling edge", int'(mcu_clk), 0);
            @(posedge xtal_clk); #1.5;
            check(mcu_clk === 1'b1, "R7", "high after sampling edge", int'(mcu_clk), 1);
            hb = idx; wait_runs(hb + 2);
            check(rlen[hb] == nb && rlen[hb + 1] == nb, "R7",
                  $sformatf("fresh period at code %0d", c), rlen[hb], nb);
        end

        // R1, R3: reset in the middle of a high phase
        at_drive(); ratio_sel = 2'd1;
        b = idx; wait_runs(b + 5);
        do begin
            @(posedge xtal_clk); #1;
        end while (mcu_clk !== 1'b1);
        rst = 1'b1;
        @(posedge xtal_clk);
        for (int k = 0; k < 3; k++) begin
            @(negedge xtal_clk); #1.5;
            check(mcu_clk === 1'b0, "R1", "low after reset mid-period", int'(mcu_clk), 0);
        end
        at_drive(); rst = 1'b0;
        #0.5; base = idx;
        wait_runs(base + 4);
        check(rlvl[base + 1] == 1'b1 && rlen[base + 1] == 5 && rlen[base + 2] == 5, "R3",
              "divide-by-5 after second reset", rlen[base + 1], 5);
        check(rlen[base + 3] == 3, "R3", "code 01 used after default period",
              rlen[base + 3], 3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule